// File: doc/BRIEF.md
# Comma Word Boundary Aligner

This block sits behind a clock-recovery stage and turns a stream of recovered line bits into framed 10-bit code groups. The stream arrives one bit per clock, and a strobe marks which clocks carry a bit. The aligner compares the last ten received bits against the comma character on every valid bit, so it can see the comma at any of the ten bit phases. It accepts the comma in both running-disparity forms. The phase of the comma sets the word boundary. From then on the block hands out one parallel code group, with a single-cycle valid pulse, each time ten more bits have arrived.

Phases are counted as follows. The first valid bit after reset has phase 0, and each later valid bit adds one, modulo 10. The `offset` output gives the phase of the last bit of each word at the current boundary. Framing is not declared at once. The aligned flag rises only after two commas in a row land on the same boundary.

While the flag is low, a comma at any other phase moves the boundary straight to that phase, which is a bit slip. While the flag is high, stray commas at other phases are tolerated. Only four words in a row that each contain such a misplaced comma drop the flag. The boundary then moves to the phase of the last misplaced comma. The block does no 8b/10b decoding, clock recovery or clock-domain crossing.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted and right after it, `word_vld` and `aligned` are 0, and `word` and `offset` are 0.
- R2: Before the first comma has been received, `word_vld` stays 0 whatever non-comma bits arrive.
- R3: A comma (0011111010 or 1100000101, the first-received bit on the left) that completes at any of the ten phases is found, and that comma is emitted as a word with `offset` equal to the phase of its last bit, while `aligned` stays 0.
- R4: `aligned` rises together with the word of the second consecutive comma at the same boundary, and not earlier.
- R5: At an established boundary a word is emitted once every ten valid bits, with the first-received bit in `word[9]`.
- R6: A clock with `bit_vld` low carries no bit: it produces no word and does not advance the phase.
- R7: While `aligned` is 0 and a boundary exists, a comma at a different phase moves the boundary there at once. That comma is emitted with the new `offset`, and later words follow the new phase.
- R8: While `aligned` is 1, commas at the locked boundary keep alignment. Misplaced commas in fewer than four consecutive words change neither `aligned`, `offset` nor the word phase.
- R9: When four consecutive words each contain a misplaced comma, `aligned` falls at the end of the fourth word and `offset` moves to that comma's phase. The next word comes only when the new phase is reached, and one more comma at that phase raises `aligned` again.
- R10: Outputs are registered, and a word appears in the clock after its last bit was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld | input | 1 | High when `bit_in` carries a line bit this clock |
| bit_in | input | 1 | Recovered line bit |
| word | output | 10 | Framed code group, first-received bit in bit 9 |
| word_vld | output | 1 | One-cycle pulse per framed word |
| aligned | output | 1 | Framing confirmed |
| offset | output | 4 | Phase (0 to 9) of the last bit of each word |

## Verification
The bench builds the block with its defaults: 10-bit code groups, two commas to lock and four bad words to lose lock. At that size it can sweep every starting phase from 0 to 9, every slip distance from 1 to 9, and both comma polarities. Together these cover every `offset` value, every relative distance between the old and new boundary, and both the hunting slip and the loss-of-lock slip. Scenarios with odd starting phase also interleave idle clocks, which shows that the phase is tied to valid bits and not to clocks.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  // Framing state of the aligner.
  typedef enum logic [1:0] {
    S_SEARCH  = 2'd0,   // no boundary known yet
    S_CONFIRM = 2'd1,   // boundary known, not yet trusted
    S_LOCKED  = 2'd2    // framing confirmed
  } cwa_state_e;

endpackage

// File: rtl/cwa_bit_window.sv
module cwa_bit_window #(
  parameter int CW = 10,
  parameter int PW = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic [CW-1:0] window,
  output logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST_PH = PW'(CW - 1);

  logic [CW-2:0] hist_q, hist_n;
  logic [PW-1:0] phase_q, phase_n;

  // Current bit joins the window combinationally: the oldest bit is the MSB.
  assign window = {hist_q, bit_in};
  assign phase  = phase_q;

  always_comb begin
    hist_n  = hist_q;
    phase_n = phase_q;
    if (bit_vld) begin
      hist_n  = window[CW-2:0];
      phase_n = (phase_q == LAST_PH) ? '0 : phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      phase_q <= '0;
    end else if (bit_vld) begin
      hist_q  <= hist_n;
      phase_q <= phase_n;
    end
  end

endmodule

// File: rtl/cwa_comma_match.sv
module cwa_comma_match #(
  parameter int            CW   = 10,
  parameter logic [CW-1:0] KPAT = 10'b0011111010
) (
  input  logic [CW-1:0] window,
  output logic          hit
);

  logic [1:0] match;

  // One comparator per running-disparity form; form 1 is the complement.
  for (genvar g = 0; g < 2; g++) begin : g_form
    localparam logic [CW-1:0] FORM = (g == 0) ? KPAT : ~KPAT;
    assign match[g] = (window == FORM);
  end

  assign hit = |match;

endmodule

// File: rtl/cwa_align_ctrl.sv
module cwa_align_ctrl
  import cwa_pkg::*;
#(
  parameter int CW     = 10,
  parameter int PW     = $clog2(CW),
  parameter int LOCK_N = 2,
  parameter int LOSS_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          hit,
  input  logic [PW-1:0] phase,
  input  logic [CW-1:0] window,
  output logic [CW-1:0] word,
  output logic          word_vld,
  output logic          aligned,
  output logic [PW-1:0] offset
);

  localparam int                CONF_W   = $clog2(LOCK_N + 1);
  localparam int                BAD_W    = $clog2(LOSS_N + 1);
  localparam logic [CONF_W-1:0] LOCK_LIM = CONF_W'(LOCK_N);
  localparam logic [BAD_W-1:0]  LOSS_LIM = BAD_W'(LOSS_N);
  localparam logic [CONF_W-1:0] CONF_ONE = CONF_W'(1);
  localparam cwa_state_e        ST_AFTER_FIRST = (LOCK_N <= 1) ? S_LOCKED : S_CONFIRM;

  cwa_state_e        st_q, st_n;
  logic [PW-1:0]     off_q, off_n;
  logic [CONF_W-1:0] conf_q, conf_n;
  logic [BAD_W-1:0]  bad_q, bad_n;
  logic              mis_q, mis_n;
  logic [PW-1:0]     moff_q, moff_n;
  logic [CW-1:0]     word_q;
  logic              vld_q;
  logic              emit;
  logic              at_bnd;

  assign at_bnd = (st_q != S_SEARCH) && (phase == off_q);

  // Next-state logic
  always_comb begin
    st_n   = st_q;
    off_n  = off_q;
    conf_n = conf_q;
    bad_n  = bad_q;
    mis_n  = mis_q;
    moff_n = moff_q;
    emit   = 1'b0;
    if (bit_vld) begin
      unique case (st_q)
        S_SEARCH: begin
          bad_n = '0;
          mis_n = 1'b0;
          if (hit) begin
            emit   = 1'b1;
            off_n  = phase;
            conf_n = CONF_ONE;
            st_n   = ST_AFTER_FIRST;
          end
        end
        S_CONFIRM: begin
          bad_n = '0;
          mis_n = 1'b0;
          if (hit && at_bnd) begin
            emit   = 1'b1;
            conf_n = conf_q + CONF_ONE;
            if ((conf_q + CONF_ONE) >= LOCK_LIM) st_n = S_LOCKED;
          end else if (hit) begin
            // slip straight to the new phase while not yet trusted
            emit   = 1'b1;
            off_n  = phase;
            conf_n = CONF_ONE;
          end else if (at_bnd) begin
            emit = 1'b1;
          end
        end
        S_LOCKED: begin
          if (at_bnd) begin
            emit  = 1'b1;
            mis_n = 1'b0;
            if (mis_q) begin
              if ((bad_q + BAD_W'(1)) >= LOSS_LIM) begin
                st_n   = S_CONFIRM;
                off_n  = moff_q;
                conf_n = CONF_ONE;
                bad_n  = '0;
              end else begin
                bad_n = bad_q + BAD_W'(1);
              end
            end else begin
              bad_n = '0;
            end
          end else if (hit) begin
            mis_n  = 1'b1;
            moff_n = phase;
          end
        end
        default: st_n = S_SEARCH;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_SEARCH;
      off_q  <= '0;
      conf_q <= '0;
      bad_q  <= '0;
      mis_q  <= 1'b0;
      moff_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= emit;
      if (emit) word_q <= window;
      if (bit_vld) begin
        st_q   <= st_n;
        off_q  <= off_n;
        conf_q <= conf_n;
        bad_q  <= bad_n;
        mis_q  <= mis_n;
        moff_q <= moff_n;
      end
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;
  assign aligned  = (st_q == S_LOCKED);
  assign offset   = off_q;

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int            CW     = 10,
  parameter logic [CW-1:0] KPAT   = 10'b0011111010,
  parameter int            LOCK_N = 2,
  parameter int            LOSS_N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_vld,
  input  logic                   bit_in,
  output logic [CW-1:0]          word,
  output logic                   word_vld,
  output logic                   aligned,
  output logic [$clog2(CW)-1:0]  offset
);

  localparam int PW = $clog2(CW);

  logic [CW-1:0] window;
  logic [PW-1:0] phase;
  logic          hit;

  cwa_bit_window #(.CW(CW), .PW(PW)) i_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .window  (window),
    .phase   (phase)
  );

  cwa_comma_match #(.CW(CW), .KPAT(KPAT)) i_match (
    .window (window),
    .hit    (hit)
  );

  cwa_align_ctrl #(.CW(CW), .PW(PW), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .hit      (hit),
    .phase    (phase),
    .window   (window),
    .word     (word),
    .word_vld (word_vld),
    .aligned  (aligned),
    .offset   (offset)
  );

endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int            CW   = 10,
  parameter logic [CW-1:0] KPAT = 10'b0011111010
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bit_vld,
  input logic [CW-1:0]         word,
  input logic                  word_vld,
  input logic                  aligned,
  input logic [$clog2(CW)-1:0] offset
);

  logic       bv_d;
  logic [7:0] gap;

  // Valid bits seen since the last emitted word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv_d <= 1'b0;
      gap  <= '0;
    end else begin
      bv_d <= bit_vld;
      if (word_vld)                  gap <= '0;
      else if (bv_d && gap != 8'hFF) gap <= gap + 8'd1;
    end
  end

  // R6: a clock without a bit never yields a word on the next clock
  p_idle_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !word_vld);

  // R3: the reported phase always lies within one code group
  p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offset < ($clog2(CW))'(CW));

  // R4: lock is declared on the word of a comma
  p_lock_on_comma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (word_vld && (word == KPAT || word == ~KPAT)));

  // R8: the boundary does not move while alignment holds
  p_offset_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && $past(aligned)) |-> (offset == $past(offset)));

  // R5: locked words are spaced by exactly one code group of valid bits
  p_word_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && aligned && $past(aligned)) |-> (gap == 8'(CW - 1)));

endmodule

bind comma_word_aligner cwa_checker #(.CW(CW), .KPAT(KPAT)) i_cwa_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_vld  (bit_vld),
  .word     (word),
  .word_vld (word_vld),
  .aligned  (aligned),
  .offset   (offset)
);

// File: tb/test_comma_word_aligner.sv
`timescale 1ns/1ps
module test_comma_word_aligner;

  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;
  localparam logic [9:0] DW = 10'b0101010101;

  logic       clk;
  logic       rst_n;
  logic       bit_vld;
  logic       bit_in;
  logic [9:0] word;
  logic       word_vld;
  logic       aligned;
  logic [3:0] offset;

  int n_chk;
  int n_err;
  int nb;
  bit gap_en;
  bit done;
  logic [63:0] seg;
  logic [63:0] mask;
  int seg_len;

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  comma_word_aligner i_comma_word_aligner (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .word     (word),
    .word_vld (word_vld),
    .aligned  (aligned),
    .offset   (offset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // R10: each bit is sampled one clock after it was presented.
  task automatic send_bit(input logic b, input logic exp_vld, input string req);
    if (gap_en && (nb % 3 == 1)) begin
      bit_vld = 1'b0;
      bit_in  = ~b;
      @(negedge clk);
      chk(word_vld == 1'b0, "R6", "word_vld on idle clock", int'(word_vld), 0);
    end
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    nb++;
    chk(word_vld == exp_vld, req, "word_vld", int'(word_vld), int'(exp_vld));
  endtask

  task automatic seg_add(input logic [9:0] val, input int n);
    logic [63:0] v;
    v = {54'd0, val} & ((64'd1 << n) - 64'd1);
    seg = (seg << n) | v;
    seg_len += n;
  endtask

  task automatic alt_add(input int n);
    if (n > 0) seg_add(DW >> (10 - n), n);
  endtask

  task automatic mark(input int rel);
    mask[rel] = 1'b1;
  endtask

  task automatic seg_send(input string req);
    for (int i = 0; i < seg_len; i++)
      send_bit(seg[seg_len-1-i], mask[i], req);
    seg     = '0;
    mask    = '0;
    seg_len = 0;
  endtask

  task automatic do_reset();
    bit_vld = 1'b0;
    bit_in  = 1'b0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    chk(word_vld == 1'b0, "R1", "word_vld in reset", int'(word_vld), 0);
    chk(aligned == 1'b0,  "R1", "aligned in reset",  int'(aligned), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word == 10'd0 && word_vld == 1'b0, "R1", "word after reset", int'(word), 0);
    chk(offset == 4'd0 && aligned == 1'b0, "R1", "offset after reset", int'(offset), 0);
    nb = 0;
  endtask

  task automatic scenario(input int p, input int s, input bit pol);
    logic [9:0] ka;
    logic [9:0] kb;
    int off;
    ka = pol ? KP : KN;
    kb = ~ka;
    do_reset();
    gap_en = (p % 2 == 1);

    // R2: filler before any comma
    alt_add(p);
    seg_send("R2");

    // R3: first comma ends at phase p+9
    seg_add(ka, 10); mark(9); seg_send("R3");
    off = (p + 9) % 10;
    chk(word == ka, "R3", "first comma word", int'(word), int'(ka));
    chk(int'(offset) == off, "R3", "first offset", int'(offset), off);
    chk(aligned == 1'b0, "R4", "aligned after one comma", int'(aligned), 0);

    // R7: slip by s while hunting; old boundary still emits at rel 9
    alt_add(s); seg_add(ka, 10); mark(9); mark(s + 9); seg_send("R7");
    off = (p + 9 + s) % 10;
    chk(word == ka, "R7", "slipped comma word", int'(word), int'(ka));
    chk(int'(offset) == off, "R7", "slipped offset", int'(offset), off);
    chk(aligned == 1'b0, "R7", "aligned after slip", int'(aligned), 0);

    // R5: data word at new phase
    seg_add(DW, 10); mark(9); seg_send("R5");
    chk(word == DW, "R5", "data word", int'(word), int'(DW));
    chk(aligned == 1'b0, "R4", "aligned before second comma", int'(aligned), 0);

    // R4: second comma at same boundary locks
    seg_add(ka, 10); mark(9); seg_send("R4");
    chk(aligned == 1'b1, "R4", "aligned after second comma", int'(aligned), 1);
    chk(word == ka, "R4", "locking word", int'(word), int'(ka));

    seg_add(DW, 10); mark(9); seg_send("R10");
    chk(word == DW, "R5", "locked data word", int'(word), int'(DW));

    // R8: other polarity at locked boundary
    seg_add(kb, 10); mark(9); seg_send("R8");
    chk(aligned == 1'b1 && word == kb, "R8", "comma at lock", int'(word), int'(kb));

    // R8: three words with a misplaced comma are tolerated
    alt_add(s); seg_add(ka, 10); seg_add(ka, 10); seg_add(ka, 10); alt_add(10 - s);
    mark(9); mark(19); mark(29); mark(39); seg_send("R8");
    chk(aligned == 1'b1, "R8", "aligned after three bad words", int'(aligned), 1);
    chk(int'(offset) == off, "R8", "offset after three bad words", int'(offset), off);
    seg_add(DW, 10); mark(9); seg_send("R8");
    chk(word == DW, "R8", "word phase kept", int'(word), int'(DW));

    // R9: four bad words drop lock and move the boundary
    alt_add(s); seg_add(ka, 10); seg_add(ka, 10); seg_add(ka, 10); seg_add(ka, 10);
    alt_add(10 - s);
    mark(9); mark(19); mark(29); mark(39); mark(49); seg_send("R9");
    off = (off + s) % 10;
    chk(aligned == 1'b0, "R9", "aligned after four bad words", int'(aligned), 0);
    chk(int'(offset) == off, "R9", "offset after loss", int'(offset), off);

    alt_add(s); mark(s - 1); seg_send("R9");
    chk(aligned == 1'b0, "R9", "aligned at first new boundary", int'(aligned), 0);

    seg_add(ka, 10); mark(9); seg_send("R9");
    chk(aligned == 1'b1, "R9", "relock", int'(aligned), 1);
    chk(word == ka && int'(offset) == off, "R9", "relock offset", int'(offset), off);

    bit_vld = 1'b0;
    gap_en  = 1'b0;
  endtask

  initial begin
    n_chk   = 0;
    n_err   = 0;
    nb      = 0;
    gap_en  = 1'b0;
    done    = 1'b0;
    seg     = '0;
    mask    = '0;
    seg_len = 0;
    rst_n   = 1'b0;
    bit_vld = 1'b0;
    bit_in  = 1'b0;
    @(negedge clk);
    for (int pol = 0; pol < 2; pol++)
      for (int p = 0; p < 10; p++)
        for (int s = 1; s < 10; s++)
          scenario(p, s, pol[0]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule